// File: doc/BRIEF.md
# Analog Test Bus Switch Controller

This block drives the ten switch enables that tie a device's two analog test pins to its internal analog test buses. A 4-bit code word is shifted in through a test-data chain clocked by the test clock and steered by the TAP controller's capture, shift and update strobes. Once the code is updated, it is decoded together with the current instruction class into one of ten legal switch patterns. The decoded pattern is held in a register that drives the switches.

The switches can only take one of the ten legal patterns. A code/instruction pair that has no defined mode produces the safe pattern, which isolates and clamps both internal buses, and raises a flag. Instructions that do not use the analog bus force the same safe pattern with the flag low. Shifting a new code never disturbs the switches. The applied code is captured back into the chain so it can be read out.

Top module: `atbic_ctrl`

## Requirements
- R1: While `shift_i` is high and `capture_i` is low, each rising `tck` moves the chain one bit: `sdi_i` enters at the top bit and `sdo_o` shows the chain's bit 0. A code is therefore shifted in D2 first and Ca (code bit 3, the MSB) last.
- R2: On a rising `tck` with `capture_i` high, the chain loads the currently applied code. Capture takes priority over shift.
- R3: The applied code changes only on a rising `tck` with `update_i` high, where it takes the chain contents. The switch register reloads from the decoder on every rising `tck`, so the switches follow a new code or class one edge after the code is updated.
- R4: `sw_o[9]` is S1 and `sw_o[0]` is S10. The patterns, written S1..S10, are: P0=0000000011, P1=0000010010, P2=0000100001, P3=0000110000, P4=0011000011, P5=0110000011, P6=1001000011, P7=1100000011, P8=0000011010, P9=0000100101.
- R5: With `icls_i`=01 (boundary-test class: EXTEST, CLAMP, RUNBIST), codes 0000 to 0111 give P0 to P7 in order, 1000 gives P0, 1001 gives P8 and 1010 gives P9.
- R6: With `icls_i`=10 (probe class: PROBE, INTEST), codes 0000 to 0011 give P0 to P3.
- R7: With `icls_i`=00 (mission mode and the non-analog instructions), the switches show P0 and `undef_o` is low for every code.
- R8: Undefined pairs give P0 with `undef_o` high. These are codes 1011 to 1111 under class 01, codes 0100 to 1111 under class 10, and every code under class 11.
- R9: When `trst_n` is low, the applied code and the chain are cleared at once, without waiting for a clock. The switches show P0 and `undef_o` is low.
- R10: Capturing and shifting leave `sw_o` and `undef_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_i | input | 1 | Capture strobe from the TAP controller |
| shift_i | input | 1 | Shift strobe from the TAP controller |
| update_i | input | 1 | Update strobe from the TAP controller |
| sdi_i | input | 1 | Serial data into the chain |
| icls_i | input | 2 | Instruction class: 00 passive, 01 boundary test, 10 probe, 11 reserved |
| sdo_o | output | 1 | Serial data out of the chain |
| sw_o | output | 10 | Registered switch enables, S1 at bit 9 |
| undef_o | output | 1 | High when the code/class pair has no defined mode |

## Verification
The bench builds the block with its default parameters: a 4-bit code, ten switches, and serial out taken directly from the chain register (`SDO_NEG_EDGE`=0). With serial out undelayed, each bit can be read before the edge that shifts it, so a captured code can be compared bit for bit. With these values the bench can reach all sixteen codes under all four instruction classes, including the reserved class. It also covers a class change made without any update, and a reset asserted in the middle of a clock cycle.

// File: rtl/atbic_pkg.sv
package atbic_pkg;

   localparam int ATB_CODE_W  = 4;
   localparam int ATB_SW_W    = 10;
   localparam int ATB_NUM_PAT = 10;
   localparam int ATB_IDX_W   = 4;

   typedef enum logic [1:0] {
      CLS_PASSIVE  = 2'b00,
      CLS_BOUNDARY = 2'b01,
      CLS_PROBE    = 2'b10,
      CLS_RESERVED = 2'b11
   } icls_e;

   // Switch enables for each legal pattern, bit 9 = S1 ... bit 0 = S10
   function automatic logic [ATB_SW_W-1:0] pattern_bits(input logic [ATB_IDX_W-1:0] idx);
      logic [ATB_SW_W-1:0] bits;
      case (idx)
         4'd1:    bits = 10'b0000010010;
         4'd2:    bits = 10'b0000100001;
         4'd3:    bits = 10'b0000110000;
         4'd4:    bits = 10'b0011000011;
         4'd5:    bits = 10'b0110000011;
         4'd6:    bits = 10'b1001000011;
         4'd7:    bits = 10'b1100000011;
         4'd8:    bits = 10'b0000011010;
         4'd9:    bits = 10'b0000100101;
         default: bits = 10'b0000000011;
      endcase
      return bits;
   endfunction

   localparam logic [ATB_SW_W-1:0] SAFE_PATTERN = 10'b0000000011;

endpackage

// File: rtl/atbic_code_chain.sv
module atbic_code_chain
   import atbic_pkg::*;
#(
   parameter int CODE_W       = ATB_CODE_W,
   parameter bit SDO_NEG_EDGE = 1'b0
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              capture_i,
   input  logic              shift_i,
   input  logic              update_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic [CODE_W-1:0] code_o
);

   localparam int TOP = CODE_W - 1;

   if (CODE_W < 2) begin : g_bad_code_w
      $error("atbic_code_chain: CODE_W must be at least 2");
   end

   logic [CODE_W-1:0] chain_q;
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         chain_q <= '0;
      end else if (capture_i) begin
         chain_q <= code_q;
      end else if (shift_i) begin
         chain_q <= {sdi_i, chain_q[TOP:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         code_q <= '0;
      end else if (update_i) begin
         code_q <= chain_q;
      end
   end

   if (SDO_NEG_EDGE) begin : g_sdo_retimed
      logic sdo_q;
      always_ff @(negedge tck or negedge trst_n) begin
         if (!trst_n) sdo_q <= 1'b0;
         else         sdo_q <= chain_q[0];
      end
      assign sdo_o = sdo_q;
   end else begin : g_sdo_direct
      assign sdo_o = chain_q[0];
   end

   assign code_o = code_q;

   assert_shift_moves_R1: assert property (@(posedge tck) disable iff (!trst_n)
      (shift_i && !capture_i) |=> (chain_q[TOP] == $past(sdi_i)) &&
                                  (chain_q[TOP-1:0] == $past(chain_q[TOP:1])));

   assert_capture_loads_R2: assert property (@(posedge tck) disable iff (!trst_n)
      capture_i |=> chain_q == $past(code_q));

   assert_code_holds_R3: assert property (@(posedge tck) disable iff (!trst_n)
      !update_i |=> $stable(code_q));

endmodule

// File: rtl/atbic_pattern_decode.sv
module atbic_pattern_decode
   import atbic_pkg::*;
#(
   parameter int CODE_W = ATB_CODE_W
) (
   input  logic [CODE_W-1:0]    code_i,
   input  icls_e                icls_i,
   output logic [ATB_IDX_W-1:0] idx_o,
   output logic                 undef_o
);

   if (CODE_W != 4) begin : g_bad_code_w
      $error("atbic_pattern_decode: the mode map needs a 4-bit code");
   end

   always_comb begin
      idx_o   = '0;
      undef_o = 1'b0;
      unique case (icls_i)
         CLS_PASSIVE: begin
            idx_o = '0;
         end
         CLS_BOUNDARY: begin
            if (!code_i[3]) begin
               idx_o = {1'b0, code_i[2:0]};
            end else begin
               case (code_i[2:0])
                  3'd0:    idx_o = 4'd0;
                  3'd1:    idx_o = 4'd8;
                  3'd2:    idx_o = 4'd9;
                  default: undef_o = 1'b1;
               endcase
            end
         end
         CLS_PROBE: begin
            if (code_i[3:2] == 2'b00) idx_o = {2'b00, code_i[1:0]};
            else                      undef_o = 1'b1;
         end
         default: begin
            undef_o = 1'b1;
         end
      endcase
   end

   always_comb begin
      if (undef_o) assert_undef_safe_idx_R8: assert (idx_o == '0);
      if (icls_i == CLS_PASSIVE) assert_passive_idx_R7: assert (idx_o == '0 && !undef_o);
   end

endmodule

// File: rtl/atbic_switch_reg.sv
module atbic_switch_reg
   import atbic_pkg::*;
#(
   parameter int SW_W = ATB_SW_W
) (
   input  logic                 tck,
   input  logic                 trst_n,
   input  logic [ATB_IDX_W-1:0] idx_i,
   input  logic                 undef_i,
   output logic [SW_W-1:0]      sw_o,
   output logic                 undef_o
);

   if (SW_W != ATB_SW_W) begin : g_bad_sw_w
      $error("atbic_switch_reg: SW_W must match the pattern width");
   end

   logic [SW_W-1:0] sw_q;
   logic            undef_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sw_q    <= SAFE_PATTERN;
         undef_q <= 1'b0;
      end else begin
         sw_q    <= undef_i ? SAFE_PATTERN : pattern_bits(idx_i);
         undef_q <= undef_i;
      end
   end

   assign sw_o    = sw_q;
   assign undef_o = undef_q;

   assert_undef_gives_safe_R8: assert property (@(posedge tck) disable iff (!trst_n)
      undef_q |-> sw_q == SAFE_PATTERN);

   assert_follows_index_R4: assert property (@(posedge tck) disable iff (!trst_n)
      (!undef_i && idx_i == '0) |=> sw_q == SAFE_PATTERN);

endmodule

// File: rtl/atbic_ctrl.sv
module atbic_ctrl
   import atbic_pkg::*;
#(
   parameter int CODE_W       = ATB_CODE_W,
   parameter int SW_W         = ATB_SW_W,
   parameter bit SDO_NEG_EDGE = 1'b0
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            capture_i,
   input  logic            shift_i,
   input  logic            update_i,
   input  logic            sdi_i,
   input  logic [1:0]      icls_i,
   output logic            sdo_o,
   output logic [SW_W-1:0] sw_o,
   output logic            undef_o
);

   logic [CODE_W-1:0]    code_w;
   logic [ATB_IDX_W-1:0] idx_w;
   logic                 undef_w;
   icls_e                icls_w;

   assign icls_w = icls_e'(icls_i);

   atbic_code_chain #(
      .CODE_W       (CODE_W),
      .SDO_NEG_EDGE (SDO_NEG_EDGE)
   ) u_chain (
      .tck       (tck),
      .trst_n    (trst_n),
      .capture_i (capture_i),
      .shift_i   (shift_i),
      .update_i  (update_i),
      .sdi_i     (sdi_i),
      .sdo_o     (sdo_o),
      .code_o    (code_w)
   );

   atbic_pattern_decode #(
      .CODE_W (CODE_W)
   ) u_decode (
      .code_i  (code_w),
      .icls_i  (icls_w),
      .idx_o   (idx_w),
      .undef_o (undef_w)
   );

   atbic_switch_reg #(
      .SW_W (SW_W)
   ) u_switch (
      .tck     (tck),
      .trst_n  (trst_n),
      .idx_i   (idx_w),
      .undef_i (undef_w),
      .sw_o    (sw_o),
      .undef_o (undef_o)
   );

   assert_passive_forces_safe_R7: assert property (@(posedge tck) disable iff (!trst_n)
      (icls_i == 2'b00) |=> (sw_o == SAFE_PATTERN) && !undef_o);

   assert_reserved_flags_R8: assert property (@(posedge tck) disable iff (!trst_n)
      (icls_i == 2'b11) |=> undef_o);

   assert_shift_keeps_switches_R10: assert property (@(posedge tck) disable iff (!trst_n)
      ($past(shift_i) && shift_i && !update_i && $stable(icls_i)) |=> $stable(sw_o));

endmodule

// File: tb/atbic_ctrl_test.sv
module atbic_ctrl_test;

   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic       capture_i = 1'b0;
   logic       shift_i = 1'b0;
   logic       update_i = 1'b0;
   logic       sdi_i = 1'b0;
   logic [1:0] icls_i = 2'b00;
   logic       sdo_o;
   logic [9:0] sw_o;
   logic       undef_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 tck = ~tck;

   atbic_ctrl uut (
      .tck(tck), .trst_n(trst_n), .capture_i(capture_i), .shift_i(shift_i),
      .update_i(update_i), .sdi_i(sdi_i), .icls_i(icls_i),
      .sdo_o(sdo_o), .sw_o(sw_o), .undef_o(undef_o)
   );

   // S1..S10 for P0..P9
   localparam logic [9:0] PAT [10] = '{
      10'b0000000011, 10'b0000010010, 10'b0000100001, 10'b0000110000,
      10'b0011000011, 10'b0110000011, 10'b1001000011, 10'b1100000011,
      10'b0000011010, 10'b0000100101 };

   // per code: {boundary-class pattern, probe-class pattern}, F = undefined
   localparam logic [7:0] MODE_MAP [16] = '{
      8'h00, 8'h11, 8'h22, 8'h33, 8'h4F, 8'h5F, 8'h6F, 8'h7F,
      8'h0F, 8'h8F, 8'h9F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic shift_in(input logic [3:0] code);
      shift_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         sdi_i = code[i];
         @(negedge tck);
      end
      shift_i = 1'b0;
   endtask

   task automatic apply(input logic [3:0] code, input logic [1:0] cls);
      icls_i = cls;
      shift_in(code);
      update_i = 1'b1;
      @(negedge tck);
      update_i = 1'b0;
      @(negedge tck);
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge tck);
      // R9: reset state
      check("R9", "sw in reset", sw_o, PAT[0]);
      check("R9", "flag in reset", undef_o, 0);
      check("R9", "sdo in reset", sdo_o, 0);
      @(negedge tck);
      trst_n = 1'b1;
      @(negedge tck);

      // Table walk: every code under every class (R4..R8)
      for (int c = 0; c < 4; c++) begin
         for (int k = 0; k < 16; k++) begin
            logic [3:0] idx;
            string req;
            if (c == 0)      begin idx = 4'h0;               req = "R7"; end
            else if (c == 1) begin idx = MODE_MAP[k][7:4];   req = "R5"; end
            else if (c == 2) begin idx = MODE_MAP[k][3:0];   req = "R6"; end
            else             begin idx = 4'hF;               req = "R8"; end
            if (idx == 4'hF) req = "R8";
            apply(k[3:0], c[1:0]);
            check(req, $sformatf("R4 sw cls=%0d code=%0h", c, k), sw_o,
                  (idx == 4'hF) ? PAT[0] : PAT[idx]);
            check(req, $sformatf("flag cls=%0d code=%0h", c, k), undef_o,
                  (idx == 4'hF) ? 1 : 0);
         end
      end

      // R2 / R1 / R10: capture applied code 0110 and shift it out
      apply(4'b0110, 2'b01);
      check("R5", "P6 applied", sw_o, PAT[6]);
      capture_i = 1'b1;
      @(negedge tck);
      capture_i = 1'b0;
      check("R10", "sw after capture", sw_o, PAT[6]);
      shift_i = 1'b1;
      sdi_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         check("R2", $sformatf("R1 sdo bit %0d", i), sdo_o, (4'b0110 >> i) & 1);
         @(negedge tck);
         check("R10", "sw during shift", sw_o, PAT[6]);
         check("R10", "flag during shift", undef_o, 0);
      end
      shift_i = 1'b0;
      @(negedge tck);
      // R3: chain now 1111, no update, switches hold
      check("R3", "sw without update", sw_o, PAT[6]);
      check("R1", "sdo after shifting ones", sdo_o, 1);

      // R3 / R8: class change alone moves the switches one edge later
      icls_i = 2'b10;
      @(negedge tck);
      check("R8", "R3 class change sw", sw_o, PAT[0]);
      check("R8", "R3 class change flag", undef_o, 1);
      icls_i = 2'b01;
      @(negedge tck);
      check("R3", "class back sw", sw_o, PAT[6]);

      // R1: Ca is the last bit shifted (1001 -> P8)
      apply(4'b1001, 2'b01);
      check("R1", "R5 msb order P8", sw_o, PAT[8]);

      // R9: asynchronous reset in mid-cycle
      apply(4'b0011, 2'b01);
      check("R5", "P3 applied", sw_o, PAT[3]);
      #5 trst_n = 1'b0;
      #1;
      check("R9", "async sw", sw_o, PAT[0]);
      check("R9", "async flag", undef_o, 0);
      check("R9", "async sdo", sdo_o, 0);
      @(negedge tck);
      trst_n = 1'b1;
      @(negedge tck);
      capture_i = 1'b1;
      @(negedge tck);
      capture_i = 1'b0;
      check("R2", "captured code after reset", sdo_o, 0);
      check("R9", "sw after reset release", sw_o, PAT[0]);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule